// File: doc/BRIEF.md
# Write-Masked Soft Reset Register Bank

This block holds the software-controlled reset lines for a set of sub-blocks. It has three 16-bit control registers on a simple write bus. Each register bit drives one active-high reset output. A 32-bit write word carries the new data in bits 15:0 and a per-bit write enable in bits 31:16. A data bit k changes only when bit k+16 of the same word is set. Software can therefore assert or release a single reset without first reading the register back and merging the change.

Each register has a fixed set of implemented bit positions, given by a parameter. Positions that are not implemented always read as zero, always drive zero, and ignore writes. The read port is combinational. It returns the selected register in the lower half of the word and zeros in the upper half. A write to an address with no register behind it changes nothing and raises a one-cycle error pulse. The block's own reset is asynchronous and active low, and its release is synchronised to the clock. While it is applied, every implemented reset line is driven asserted.

Top module: `soft_reset_bank`

## Requirements
- R1: While `rst_n` is low, and after it is released, `rst_out` equals the implemented-bit masks. Register 0 occupies `rst_out[15:0]`, register 1 occupies `rst_out[31:16]` and register 2 occupies `rst_out[47:32]`.
- R2: A write updates data bit k of a register only when bit k+16 of `wr_data` is 1. All other bits keep their value.
- R3: Writing 1 to a bit with its mask bit set asserts that reset line. Writing 0 with its mask bit set releases it. The change is visible on `rst_out` and `rd_data` in the cycle after the write edge.
- R4: The implemented bits are fixed per register. Register 0 has bits 0, 1, 2, 3, 5, 7, 11, 12 and 13 (mask 0x38AF). Register 1 has bits 0 to 7 (mask 0x00FF). Register 2 has bit 0 and bits 2 to 14 (mask 0x7FFD). Every other bit always reads and drives 0, whatever is written.
- R5: `rd_data` returns the register at `rd_addr` in bits 15:0, with bits 31:16 equal to zero. An address of 3 or above reads as all zeros.
- R6: A write to address 3 or above changes no register. It sets `wr_err` high for exactly the cycle after that write edge.
- R7: While `wr_en` is low, no register changes and `wr_err` stays low.
- R8: Pulling `rst_n` low returns `rst_out` to the R1 value at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset for the bank |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 32 | Mask in bits 31:16, data in bits 15:0 |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 32 | Read data, upper half zero |
| wr_err | output | 1 | One-cycle pulse after a write to an unmapped address |
| rst_out | output | 48 | Reset lines, 16 per register |

## Verification
The bench uses the default parameters: three 16-bit registers behind a 4-bit address. This makes all 48 bit positions and all 16 addresses (13 of them unmapped) small enough to sweep completely. Every bit position is released and asserted by a masked write. Every bit position is also written with its mask clear, to show that nothing changes. A pseudo-random run of mixed-address writes is compared, after each write, against an arithmetic model of masked merging under the fixed implemented masks.

// File: rtl/soft_reset_pkg.sv
package soft_reset_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned WORD_W = 2 * REG_W;
  localparam int unsigned NREGS  = 3;
  localparam logic [NREGS*REG_W-1:0] DEFAULT_IMPL = {16'h7FFD, 16'h00FF, 16'h38AF};
endpackage

// File: rtl/srb_rst_sync.sv
module srb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb chain_nxt = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/srb_addr_decode.sv
module srb_addr_decode #(
  parameter int unsigned NUM_REGS = 3,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] sel,
  output logic                hit
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign sel[i] = (addr == ADDR_W'(i));
  end
  assign hit = |sel;

  always_comb begin
    assert_sel_onehot_R6: assert ($onehot0(sel));
  end
endmodule

// File: rtl/srb_mask_reg.sv
module srb_mask_reg #(
  parameter int unsigned REG_W = 16,
  parameter logic [REG_W-1:0] IMPL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_mask,
  input  logic [REG_W-1:0] wr_val,
  output logic [REG_W-1:0] q
);
  logic [REG_W-1:0] q_nxt;
  logic [REG_W-1:0] eff_mask;

  always_comb begin
    eff_mask = wr_mask & IMPL;
    q_nxt    = (q & ~eff_mask) | (wr_val & eff_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= IMPL;
    else if (wr_sel) q <= q_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst_n) begin
      assert_unimpl_zero_R4: assert ((q & ~IMPL) == '0);
    end
  end

  assert_unmasked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((q ^ $past(q)) & ~($past(wr_sel) ? $past(wr_mask) : {REG_W{1'b0}})) == '0);

  assert_masked_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_sel) |-> (((q ^ $past(wr_val)) & $past(wr_mask) & IMPL) == '0));
endmodule

// File: rtl/soft_reset_bank.sv
module soft_reset_bank #(
  parameter int unsigned NUM_REGS = soft_reset_pkg::NREGS,
  parameter int unsigned REG_W    = soft_reset_pkg::REG_W,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [NUM_REGS*REG_W-1:0] IMPL_MASKS = soft_reset_pkg::DEFAULT_IMPL
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [2*REG_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [2*REG_W-1:0]        rd_data,
  output logic                      wr_err,
  output logic [NUM_REGS*REG_W-1:0] rst_out
);
  localparam int unsigned WORD_W = 2 * REG_W;

  logic                rst_sync_n;
  logic [NUM_REGS-1:0] wr_dec;
  logic                wr_hit;
  logic                wr_go;
  logic                err_nxt;
  logic [REG_W-1:0]    reg_q [NUM_REGS];

  srb_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  srb_addr_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_wdec (
    .addr(wr_addr), .sel(wr_dec), .hit(wr_hit)
  );

  assign wr_go = wr_en & rst_sync_n;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    srb_mask_reg #(
      .REG_W(REG_W),
      .IMPL(IMPL_MASKS[i*REG_W +: REG_W])
    ) u_reg (
      .clk(clk),
      .rst_n(rst_sync_n),
      .wr_sel(wr_go & wr_dec[i]),
      .wr_mask(wr_data[WORD_W-1:REG_W]),
      .wr_val(wr_data[REG_W-1:0]),
      .q(reg_q[i])
    );
    assign rst_out[i*REG_W +: REG_W] = reg_q[i];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data[REG_W-1:0] = reg_q[i];
    end
  end

  always_comb err_nxt = wr_go & ~wr_hit;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) wr_err <= 1'b0;
    else             wr_err <= err_nxt;
  end

  assert_bad_write_flag_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(wr_go && !wr_hit) |-> wr_err);

  assert_bad_write_inert_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(wr_go && !wr_hit) |-> $stable(rst_out));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(!wr_en) |-> ($stable(rst_out) && !wr_err));
endmodule

// File: tb/soft_reset_bank_tb.sv
module soft_reset_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 3;
  localparam int AW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        wr_err;
  logic [47:0] rst_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] impl [NR];
  logic [15:0] mdl [NR];
  logic [31:0] lfsr = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  soft_reset_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_err(wr_err), .rst_out(rst_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, {16'h0, rst_out}, {16'h0, mdl[2], mdl[1], mdl[0]});
    for (int a = 0; a < 16; a++) begin
      rd_addr = 4'(a);
      #1;
      chk("R5", {32'h0, rd_data}, (a < NR) ? {48'h0, mdl[a]} : 64'h0);
    end
  endtask

  task automatic model_write(input int a, input logic [31:0] w);
    if (a < NR) mdl[a] = ((mdl[a] & ~w[31:16]) | (w[15:0] & w[31:16])) & impl[a];
  endtask

  task automatic do_write(input int a, input logic [31:0] w, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = w;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    model_write(a, w);
    chk("R6", {63'h0, wr_err}, {63'h0, (a >= NR)});
    check_all(req);
  endtask

  task automatic reset_model();
    for (int i = 0; i < NR; i++) mdl[i] = impl[i];
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    impl[0] = 16'h38AF; impl[1] = 16'h00FF; impl[2] = 16'h7FFD;
    reset_model();
    #(CLK_PERIOD * 3);
    check_all("R1");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1");
    chk("R6", {63'h0, wr_err}, 64'h0);

    // per-bit sweep: release, masked-off write, assert
    for (int r = 0; r < NR; r++) begin
      for (int k = 0; k < 16; k++) begin
        do_write(r, 32'(1) << (k + 16), "R3");
        chk("R4", {63'h0, rst_out[r*16+k]}, 64'h0);
        do_write(r, 32'(1) << k, "R2");
        chk("R2", {63'h0, rst_out[r*16+k]}, 64'h0);
        do_write(r, (32'(1) << (k + 16)) | (32'(1) << k), "R3");
        chk("R4", {63'h0, rst_out[r*16+k]}, {63'h0, impl[r][k]});
      end
    end

    // unmapped writes
    for (int a = NR; a < 16; a++) begin
      do_write(a, 32'hFFFF_0000, "R6");
      @(negedge clk);
      chk("R6", {63'h0, wr_err}, 64'h0);
    end

    // idle bus with active-looking data
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 4'd1; wr_data = 32'hFFFF_0000;
    repeat (3) @(negedge clk);
    chk("R7", {63'h0, wr_err}, 64'h0);
    check_all("R7");
    wr_data = '0;

    // pseudo-random mixed writes
    for (int n = 0; n < 300; n++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      do_write(int'(lfsr[3:0]) % 5, {lfsr[31:16], lfsr[15:0] ^ lfsr[31:16]}, "R2");
    end

    // asynchronous reset between edges
    do_write(0, 32'hFFFF_0000, "R3");
    do_write(2, 32'hFFFF_0000, "R3");
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    reset_model();
    chk("R8", {16'h0, rst_out}, {16'h0, impl[2], impl[1], impl[0]});
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule